// File: doc/BRIEF.md
# ChaCha20 Keystream Block Generator

This block turns a 256-bit key, a 96-bit nonce and a 32-bit block counter into one 512-bit ChaCha20 keystream block. It also gives the ciphertext for one 512-bit plaintext block. The core holds a working copy of the 16-word state and a frozen copy of the state as first loaded. Four quarter-round units work side by side, so each clock cycle runs one whole round. The rounds alternate between column rounds and diagonal rounds. When the last round is done, the frozen copy is added back word by word to form the keystream.

The block is used through a start/done handshake. While the core is idle, a single-cycle start captures the inputs. Twenty cycles later the keystream is registered and a one-cycle done pulse is raised. The keystream then holds until the next accepted start. The ciphertext is the held keystream XORed with whatever is on the plaintext port, so one keystream block can be applied to a plaintext word that arrives late.

Top module: `chacha_block`

## Requirements
- R1: After reset, busy and done are 0 and keystream is all zeros.
- R2: A start seen on a clock edge while busy is 0 loads the state, and busy reads 1 after that edge.
- R3: Done rises exactly 20 clock edges after the edge that accepted start, and busy falls on that same edge.
- R4: Done is high for exactly one cycle and is never high while busy is high.
- R5: While busy, start is ignored and so are changes on key, nonce and counter; the run keeps its timing and its result.
- R6: The state is laid out with words 0-3 = 0x61707865, 0x3320646e, 0x79622d32, 0x6b206574, words 4-11 = key, word 12 = counter and words 13-15 = nonce. Ten column/diagonal round pairs run, starting with a column round. Column groups are (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15); diagonal groups are (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14). The keystream is each final word plus its initial word, modulo 2^32.
- R7: Byte i of key and nonce is bits [8i+7:8i], and word j is bits [32j+31:32j], so words are packed little-endian. Keystream word k is placed at bits [32k+31:32k].
- R8: Ciphertext always equals keystream XOR plaintext, and follows the plaintext port without a start.
- R9: While busy is 0, keystream does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new block; taken only when idle |
| key | input | 256 | Key, byte i at bits [8i+7:8i] |
| nonce | input | 96 | Nonce, byte i at bits [8i+7:8i] |
| counter | input | 32 | Block counter (state word 12) |
| plaintext | input | 512 | Plaintext block |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when the keystream is ready |
| keystream | output | 512 | Held keystream block, word k at bits [32k+31:32k] |
| ciphertext | output | 512 | keystream XOR plaintext |

## Verification
The hardest case to reach is a start request, together with new key, nonce and counter values, arriving in the middle of a run. If this case were mishandled, the running state would be reloaded silently. The stimulus raises start partway through the twenty rounds while all the other inputs are changed. The test then checks that done still arrives on the original cycle and that the keystream matches the first set of inputs. A published-style vector and an independent software model of the rounds pin down the word layout, the order of the rounds and the diagonal index groups.

// File: rtl/chacha_block.sv
module chacha_block #(
  parameter int ROUNDS = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [255:0] key,
  input  logic [95:0]  nonce,
  input  logic [31:0]  counter,
  input  logic [511:0] plaintext,
  output logic         busy,
  output logic         done,
  output logic [511:0] keystream,
  output logic [511:0] ciphertext
);
  localparam int RW = $clog2(ROUNDS);
  localparam logic [127:0] SIGMA = {32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};

  logic [511:0] init_q, work_q, work_d, ks_q, fin;
  logic [511:0] pin, pout;
  logic [RW-1:0] rnd_q;
  logic          diag;
  logic          last;

  wire [511:0] load_st = {nonce, counter, key, SIGMA};

  assign diag = rnd_q[0];
  assign last = (rnd_q == RW'(ROUNDS - 1));

  function automatic logic [127:0] qround(input logic [31:0] a0, b0, c0, d0);
    logic [31:0] a, b, c, d;
    a = a0 + b0; d = d0 ^ a; d = {d[15:0], d[31:16]};
    c = c0 + d;  b = b0 ^ c; b = {b[19:0], b[31:20]};
    a = a + b;   d = d ^ a;  d = {d[23:0], d[31:24]};
    c = c + d;   b = b ^ c;  b = {b[24:0], b[31:25]};
    return {d, c, b, a};
  endfunction

  // Diagonal rounds: rotate row r left by r words so diagonals line up as columns.
  for (genvar w = 0; w < 16; w++) begin : g_word
    localparam int R  = w / 4;
    localparam int C  = w % 4;
    localparam int SP = R * 4 + (C + R) % 4;
    localparam int SU = R * 4 + (C - R + 4) % 4;
    assign pin[32*w +: 32]    = diag ? work_q[32*SP +: 32] : work_q[32*w +: 32];
    assign work_d[32*w +: 32] = diag ? pout[32*SU +: 32]   : pout[32*w +: 32];
    assign fin[32*w +: 32]    = work_d[32*w +: 32] + init_q[32*w +: 32];
  end

  for (genvar q = 0; q < 4; q++) begin : g_qr
    logic [127:0] r;
    assign r = qround(pin[32*q +: 32], pin[32*(q+4) +: 32],
                      pin[32*(q+8) +: 32], pin[32*(q+12) +: 32]);
    assign pout[32*q      +: 32] = r[31:0];
    assign pout[32*(q+4)  +: 32] = r[63:32];
    assign pout[32*(q+8)  +: 32] = r[95:64];
    assign pout[32*(q+12) +: 32] = r[127:96];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      rnd_q  <= '0;
      init_q <= '0;
      work_q <= '0;
      ks_q   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          rnd_q  <= '0;
          init_q <= load_st;
          work_q <= load_st;
        end
      end else begin
        work_q <= work_d;
        rnd_q  <= rnd_q + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          ks_q <= fin;
        end
      end
    end
  end

  assign keystream  = ks_q;
  assign ciphertext = ks_q ^ plaintext;

  // Cycle count since the accepted start, used only by the latency check.
  logic [RW:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lat_q <= '0;
    else if (!busy && start) lat_q <= '0;
    else if (busy)         lat_q <= lat_q + 1'b1;
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_q == (RW+1)'(ROUNDS));
  assert_busy_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  assert_run_continues_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  assert_ks_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(keystream));
endmodule

// File: tb/chacha_block_bench.sv
module chacha_block_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [255:0] key = '0;
  logic [95:0] nonce = '0;
  logic [31:0] counter = '0;
  logic [511:0] plaintext = '0;
  logic busy, done;
  logic [511:0] keystream, ciphertext;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chacha_block u_chacha_block (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .nonce(nonce),
    .counter(counter), .plaintext(plaintext), .busy(busy), .done(done),
    .keystream(keystream), .ciphertext(ciphertext));

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [511:0] model(input logic [255:0] k, input logic [95:0] n, input logic [31:0] c);
    logic [31:0] s[16];
    logic [31:0] x[16];
    int grp[8][4] = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
                      '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};
    logic [511:0] res;
    s[0] = 32'h61707865; s[1] = 32'h3320646e; s[2] = 32'h79622d32; s[3] = 32'h6b206574;
    for (int j = 0; j < 8; j++) s[4+j] = k[32*j +: 32];
    s[12] = c;
    for (int j = 0; j < 3; j++) s[13+j] = n[32*j +: 32];
    x = s;
    for (int rd = 0; rd < 20; rd++) begin
      for (int g = 0; g < 4; g++) begin
        int ia, ib, ic, id;
        ia = grp[(rd%2)*4+g][0]; ib = grp[(rd%2)*4+g][1];
        ic = grp[(rd%2)*4+g][2]; id = grp[(rd%2)*4+g][3];
        x[ia] = x[ia] + x[ib]; x[id] = rotl(x[id] ^ x[ia], 16);
        x[ic] = x[ic] + x[id]; x[ib] = rotl(x[ib] ^ x[ic], 12);
        x[ia] = x[ia] + x[ib]; x[id] = rotl(x[id] ^ x[ia], 8);
        x[ic] = x[ic] + x[id]; x[ib] = rotl(x[ib] ^ x[ic], 7);
      end
    end
    for (int j = 0; j < 16; j++) res[32*j +: 32] = x[j] + s[j];
    return res;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int j = 0; j < 16; j++) v[32*j +: 32] = $urandom;
    return v;
  endfunction

  // Pulse start at a negedge; returns number of edges until done.
  task automatic run(input logic [255:0] k, input logic [95:0] n, input logic [31:0] c, output int cyc);
    @(negedge clk);
    key = k; nonce = n; counter = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", 512'(busy), 512'(1));
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (done !== 1'b1 && cyc < 100);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R1 busy reset", 512'(busy), 512'(0));
    chk(done === 1'b0, "R1 done reset", 512'(done), 512'(0));
    chk(keystream === '0, "R1 keystream reset", keystream, '0);
  endtask

  task automatic t_vector();
    logic [255:0] k;
    logic [95:0] n;
    int cyc;
    for (int i = 0; i < 32; i++) k[8*i +: 8] = 8'(i);
    n = '0;
    n[8*3 +: 8] = 8'h09;
    n[8*7 +: 8] = 8'h4a;
    run(k, n, 32'd1, cyc);
    chk(keystream[31:0] === 32'he4e7f110, "R7 vector word0", 512'(keystream[31:0]), 512'(32'he4e7f110));
    chk(keystream[511:480] === 32'h4e3c50a2, "R7 vector word15", 512'(keystream[511:480]), 512'(32'h4e3c50a2));
    chk(keystream === model(k, n, 32'd1), "R6 vector model", keystream, model(k, n, 32'd1));
  endtask

  task automatic t_timing();
    int cyc;
    run(rnd512()[255:0], rnd512()[95:0], $urandom, cyc);
    chk(cyc == 20, "R3 latency", 512'(cyc), 512'(20));
    chk(busy === 1'b0, "R3 busy falls with done", 512'(busy), 512'(0));
    @(negedge clk);
    chk(done === 1'b0, "R4 done one cycle", 512'(done), 512'(0));
  endtask

  task automatic t_random();
    for (int t = 0; t < 6; t++) begin
      logic [255:0] k;
      logic [95:0] n;
      logic [31:0] c;
      int cyc;
      k = rnd512()[255:0]; n = rnd512()[95:0]; c = $urandom;
      plaintext = rnd512();
      run(k, n, c, cyc);
      chk(keystream === model(k, n, c), "R6 random keystream", keystream, model(k, n, c));
      chk(ciphertext === (model(k, n, c) ^ plaintext), "R8 random ciphertext", ciphertext, model(k, n, c) ^ plaintext);
    end
  endtask

  task automatic t_edges();
    int cyc;
    run({256{1'b1}}, {96{1'b1}}, 32'hffffffff, cyc);
    chk(keystream === model({256{1'b1}}, {96{1'b1}}, 32'hffffffff), "R6 all ones",
        keystream, model({256{1'b1}}, {96{1'b1}}, 32'hffffffff));
    run('0, '0, 32'd0, cyc);
    chk(keystream === model('0, '0, 32'd0), "R6 all zeros", keystream, model('0, '0, 32'd0));
  endtask

  task automatic t_busy_start();
    logic [255:0] k;
    logic [95:0] n;
    logic [31:0] c;
    int cyc;
    k = rnd512()[255:0]; n = rnd512()[95:0]; c = $urandom;
    @(negedge clk);
    key = k; nonce = n; counter = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    repeat (5) begin @(negedge clk); cyc++; end
    key = ~k; nonce = ~n; counter = ~c; start = 1'b1;
    @(negedge clk); cyc++;
    start = 1'b0;
    while (done !== 1'b1 && cyc < 100) begin @(negedge clk); cyc++; end
    chk(cyc == 20, "R5 latency with start while busy", 512'(cyc), 512'(20));
    chk(keystream === model(k, n, c), "R5 result unaffected", keystream, model(k, n, c));
  endtask

  task automatic t_hold();
    logic [511:0] ks0;
    ks0 = keystream;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      key = rnd512()[255:0]; nonce = rnd512()[95:0]; counter = $urandom;
    end
    @(negedge clk);
    chk(keystream === ks0, "R9 keystream held", keystream, ks0);
    plaintext = rnd512();
    #1;
    chk(ciphertext === (ks0 ^ plaintext), "R8 ciphertext follows plaintext", ciphertext, ks0 ^ plaintext);
    chk(busy === 1'b0, "R9 idle without start", 512'(busy), 512'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_vector();
    t_timing();
    t_random();
    t_edges();
    t_busy_start();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule